// File: doc/BRIEF.md
# Task-File Byte-Lane Bridge

This block is the register end of a 16-bit card I/O bus. It holds a small bank of byte-wide task-file registers, arranged as even/odd pairs, and maps each bus cycle onto them. Two active-low chip enables, one for each half of the bus, set the width of the access. Address bit 0, the active-low register-select line and the active-low I/O strobes complete the decode. Four cases result: idle (standby), a single byte on the low lane, a full 16-bit word, or the odd byte alone on the high lane. One register pair can therefore be reached through the low lane, the high lane or both.

On a read, the block places the selected bytes on the right lanes. It raises a separate drive enable for each lane so that the pad ring can tri-state the lanes that are not in use. On a write, it samples the data lanes while the write strobe is low. It commits the sampled bytes to the registers when the strobe returns high. Lanes that the current mode does not use never reach storage. The bus is modelled synchronously: every input is sampled on the block clock.

Top module: `tfile_lane_bridge`

## Requirements
- R1: With both chip enables high (standby), neither lane drive enable is asserted and no write changes any register, whatever the other inputs are.
- R2: An access is valid only when the register select is low and both memory strobes (output enable, write enable) are high. Otherwise nothing is driven and nothing is written.
- R3: Byte mode (low enable 0, high enable 1), read: the low lane carries the even register of the addressed pair when address bit 0 is 0, and the odd register when it is 1. The high lane drive enable stays low.
- R4: Byte mode, write: the low-lane byte goes to the even register when address bit 0 is 0, and to the odd register when it is 1. The high-lane byte changes nothing.
- R5: Word mode (both enables 0), read: the even register appears on the low lane and the odd register on the high lane. Both lane drive enables are high, and address bit 0 has no effect.
- R6: Word mode, write: the low-lane byte goes to the even register and the high-lane byte to the odd register, whatever address bit 0 is.
- R7: Odd mode (low enable 1, high enable 0), read: the odd register appears on the high lane, and the low lane drive enable stays low.
- R8: Odd mode, write: the high-lane byte goes to the odd register. The low-lane byte and the even register are left untouched.
- R9: A write takes effect on the clock edge at which the write strobe is first seen high after being low. It uses the inputs sampled on the last edge at which the strobe was low. Address bits above bit 0 select the pair, and bit 0 set means the odd register.
- R10: While the read and write strobes are both low, nothing is driven and no write is recorded.
- R11: A synchronous reset clears every register to zero.
- R12: Each output lane reads as zero whenever its drive enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_lo_n | input | 1 | Chip enable for the low byte lane, active low |
| cs_hi_n | input | 1 | Chip enable for the high byte lane, active low |
| regsel_n | input | 1 | Register-space select, active low |
| mem_oe_n | input | 1 | Memory output enable, must be high for a task-file access |
| mem_we_n | input | 1 | Memory write enable, must be high for a task-file access |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| addr | input | PAIR_AW+1 | Register address; bit 0 picks odd/even, upper bits pick the pair |
| dq_in | input | 2*DATA_W | Write data from the bus, low lane in the lower half |
| dq_out | output | 2*DATA_W | Read data toward the bus, low lane in the lower half |
| dq_oe_lo | output | 1 | Drive enable for the low lane |
| dq_oe_hi | output | 1 | Drive enable for the high lane |

## Verification
The bench builds the block with its defaults: byte-wide registers and two pair-address bits, which gives four pairs and eight registers. That bank is small enough that a few hundred random cycles write through every mode into every register many times. A full word-mode read-back after the random run then shows whether any unused lane or any disqualified cycle leaked into storage. Directed cycles cover the address-bit-0 cases in byte and word mode, data that changes on the same edge the strobe rises, and reset in mid-run.

// File: rtl/tfile_pkg.sv
package tfile_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_BYTE = 2'd1,
      MODE_WORD = 2'd2,
      MODE_ODD  = 2'd3
   } lane_mode_e;

   function automatic lane_mode_e enables_to_mode(input logic lo_n, input logic hi_n);
      lane_mode_e m;
      case ({lo_n, hi_n})
         2'b01:   m = MODE_BYTE;
         2'b00:   m = MODE_WORD;
         2'b10:   m = MODE_ODD;
         default: m = MODE_IDLE;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/tfile_decode.sv
module tfile_decode
   import tfile_pkg::*;
(
   input  logic cs_lo_n,
   input  logic cs_hi_n,
   input  logic regsel_n,
   input  logic mem_oe_n,
   input  logic mem_we_n,
   input  logic io_rd_n,
   input  logic io_wr_n,
   input  logic a0,
   output logic oe_lo,
   output logic oe_hi,
   output logic lo_from_odd,
   output logic wr_even_en,
   output logic wr_odd_en,
   output logic odd_from_hi
);

   lane_mode_e mode;
   logic       strobe_clash;
   logic       access_ok;
   logic       rd_go;
   logic       wr_go;

   always_comb begin
      mode         = enables_to_mode(cs_lo_n, cs_hi_n);
      strobe_clash = !io_rd_n && !io_wr_n;
      access_ok    = !regsel_n && mem_oe_n && mem_we_n && !strobe_clash
                     && (mode != MODE_IDLE);
      rd_go        = access_ok && !io_rd_n;
      wr_go        = access_ok && !io_wr_n;

      oe_lo        = rd_go && ((mode == MODE_BYTE) || (mode == MODE_WORD));
      oe_hi        = rd_go && ((mode == MODE_WORD) || (mode == MODE_ODD));
      lo_from_odd  = (mode == MODE_BYTE) && a0;

      wr_even_en   = wr_go && (((mode == MODE_BYTE) && !a0) || (mode == MODE_WORD));
      wr_odd_en    = wr_go && (((mode == MODE_BYTE) && a0) || (mode == MODE_WORD)
                               || (mode == MODE_ODD));
      odd_from_hi  = (mode != MODE_BYTE);
   end

endmodule

// File: rtl/tfile_wr_capture.sv
module tfile_wr_capture #(
   parameter int DATA_W  = 8,
   parameter int PAIR_AW = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 io_wr_n,
   input  logic                 even_en,
   input  logic                 odd_en,
   input  logic                 odd_from_hi,
   input  logic [PAIR_AW-1:0]   pair,
   input  logic [2*DATA_W-1:0]  dq_in,
   output logic                 commit,
   output logic [PAIR_AW-1:0]   c_pair,
   output logic                 c_even_en,
   output logic                 c_odd_en,
   output logic [DATA_W-1:0]    c_even_d,
   output logic [DATA_W-1:0]    c_odd_d
);

   logic              wr_n_q;
   logic [DATA_W-1:0] lane_lo;
   logic [DATA_W-1:0] lane_hi;

   assign lane_lo = dq_in[DATA_W-1:0];
   assign lane_hi = dq_in[2*DATA_W-1:DATA_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_n_q    <= 1'b1;
         c_pair    <= '0;
         c_even_en <= 1'b0;
         c_odd_en  <= 1'b0;
         c_even_d  <= '0;
         c_odd_d   <= '0;
      end else begin
         wr_n_q <= io_wr_n;
         if (!io_wr_n) begin
            c_pair    <= pair;
            c_even_en <= even_en;
            c_odd_en  <= odd_en;
            c_even_d  <= lane_lo;
            c_odd_d   <= odd_from_hi ? lane_hi : lane_lo;
         end
      end
   end

   assign commit = !wr_n_q && io_wr_n;

endmodule

// File: rtl/tfile_bank.sv
module tfile_bank #(
   parameter int DATA_W  = 8,
   parameter int PAIR_AW = 2
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          commit,
   input  logic [PAIR_AW-1:0]            c_pair,
   input  logic                          c_even_en,
   input  logic                          c_odd_en,
   input  logic [DATA_W-1:0]             c_even_d,
   input  logic [DATA_W-1:0]             c_odd_d,
   input  logic [PAIR_AW-1:0]            rd_pair,
   output logic [DATA_W-1:0]             rd_even,
   output logic [DATA_W-1:0]             rd_odd,
   output logic [(2<<PAIR_AW)*DATA_W-1:0] bank_flat
);

   localparam int NPAIR = 1 << PAIR_AW;

   logic [DATA_W-1:0] even_q [NPAIR];
   logic [DATA_W-1:0] odd_q  [NPAIR];

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic hit;
      assign hit = commit && (c_pair == p[PAIR_AW-1:0]);

      always_ff @(posedge clk) begin
         if (rst) begin
            even_q[p] <= '0;
            odd_q[p]  <= '0;
         end else if (hit) begin
            if (c_even_en) even_q[p] <= c_even_d;
            if (c_odd_en)  odd_q[p]  <= c_odd_d;
         end
      end

      assign bank_flat[(2*p)*DATA_W   +: DATA_W] = even_q[p];
      assign bank_flat[(2*p+1)*DATA_W +: DATA_W] = odd_q[p];
   end

   assign rd_even = even_q[rd_pair];
   assign rd_odd  = odd_q[rd_pair];

endmodule

// File: rtl/tfile_lane_bridge.sv
module tfile_lane_bridge #(
   parameter int DATA_W  = 8,
   parameter int PAIR_AW = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cs_lo_n,
   input  logic                 cs_hi_n,
   input  logic                 regsel_n,
   input  logic                 mem_oe_n,
   input  logic                 mem_we_n,
   input  logic                 io_rd_n,
   input  logic                 io_wr_n,
   input  logic [PAIR_AW:0]     addr,
   input  logic [2*DATA_W-1:0]  dq_in,
   output logic [2*DATA_W-1:0]  dq_out,
   output logic                 dq_oe_lo,
   output logic                 dq_oe_hi
);

   localparam int NLANE  = 2;
   localparam int NREG   = 2 << PAIR_AW;
   localparam int BANK_W = NREG * DATA_W;

   if (DATA_W < 1) begin : g_bad_width
      $error("tfile_lane_bridge: DATA_W must be at least 1");
   end
   if (PAIR_AW < 1 || PAIR_AW > 6) begin : g_bad_depth
      $error("tfile_lane_bridge: PAIR_AW must lie in 1..6");
   end

   logic                lo_from_odd;
   logic                odd_from_hi;
   logic                wr_even_en;
   logic                wr_odd_en;
   logic                commit;
   logic [PAIR_AW-1:0]  c_pair;
   logic                c_even_en;
   logic                c_odd_en;
   logic [DATA_W-1:0]   c_even_d;
   logic [DATA_W-1:0]   c_odd_d;
   logic [DATA_W-1:0]   rd_even;
   logic [DATA_W-1:0]   rd_odd;
   logic [BANK_W-1:0]   bank_flat;
   logic [DATA_W-1:0]   lane_val [NLANE];
   logic [NLANE-1:0]    lane_oe;

   tfile_decode u_decode (
      .cs_lo_n     (cs_lo_n),
      .cs_hi_n     (cs_hi_n),
      .regsel_n    (regsel_n),
      .mem_oe_n    (mem_oe_n),
      .mem_we_n    (mem_we_n),
      .io_rd_n     (io_rd_n),
      .io_wr_n     (io_wr_n),
      .a0          (addr[0]),
      .oe_lo       (dq_oe_lo),
      .oe_hi       (dq_oe_hi),
      .lo_from_odd (lo_from_odd),
      .wr_even_en  (wr_even_en),
      .wr_odd_en   (wr_odd_en),
      .odd_from_hi (odd_from_hi)
   );

   tfile_wr_capture #(.DATA_W(DATA_W), .PAIR_AW(PAIR_AW)) u_capture (
      .clk         (clk),
      .rst         (rst),
      .io_wr_n     (io_wr_n),
      .even_en     (wr_even_en),
      .odd_en      (wr_odd_en),
      .odd_from_hi (odd_from_hi),
      .pair        (addr[PAIR_AW:1]),
      .dq_in       (dq_in),
      .commit      (commit),
      .c_pair      (c_pair),
      .c_even_en   (c_even_en),
      .c_odd_en    (c_odd_en),
      .c_even_d    (c_even_d),
      .c_odd_d     (c_odd_d)
   );

   tfile_bank #(.DATA_W(DATA_W), .PAIR_AW(PAIR_AW)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .commit    (commit),
      .c_pair    (c_pair),
      .c_even_en (c_even_en),
      .c_odd_en  (c_odd_en),
      .c_even_d  (c_even_d),
      .c_odd_d   (c_odd_d),
      .rd_pair   (addr[PAIR_AW:1]),
      .rd_even   (rd_even),
      .rd_odd    (rd_odd),
      .bank_flat (bank_flat)
   );

   assign lane_val[0] = lo_from_odd ? rd_odd : rd_even;
   assign lane_val[1] = rd_odd;
   assign lane_oe     = {dq_oe_hi, dq_oe_lo};

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign dq_out[l*DATA_W +: DATA_W] = lane_oe[l] ? lane_val[l] : '0;
   end

endmodule

// File: rtl/tfile_lane_bridge_chk.sv
module tfile_lane_bridge_chk #(
   parameter int DATA_W  = 8,
   parameter int PAIR_AW = 2
) (
   input logic                           clk,
   input logic                           rst,
   input logic                           cs_lo_n,
   input logic                           cs_hi_n,
   input logic                           regsel_n,
   input logic                           mem_oe_n,
   input logic                           mem_we_n,
   input logic                           io_rd_n,
   input logic                           io_wr_n,
   input logic [2*DATA_W-1:0]            dq_out,
   input logic                           dq_oe_lo,
   input logic                           dq_oe_hi,
   input logic [(2<<PAIR_AW)*DATA_W-1:0] bank_flat
);

   AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      (cs_lo_n && cs_hi_n) |-> (!dq_oe_lo && !dq_oe_hi)); // R1

   AST_QUAL_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      (regsel_n || !mem_oe_n || !mem_we_n) |-> (!dq_oe_lo && !dq_oe_hi)); // R2

   AST_BYTE_HI_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!cs_lo_n && cs_hi_n) |-> !dq_oe_hi); // R3

   AST_WORD_BOTH_LANES: assert property (@(posedge clk) disable iff (rst)
      (!cs_lo_n && !cs_hi_n && !regsel_n && mem_oe_n && mem_we_n && !io_rd_n && io_wr_n)
      |-> (dq_oe_lo && dq_oe_hi)); // R5

   AST_ODD_LO_QUIET: assert property (@(posedge clk) disable iff (rst)
      (cs_lo_n && !cs_hi_n) |-> !dq_oe_lo); // R7

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(!$past(io_wr_n) && io_wr_n) |=> $stable(bank_flat)); // R9

   AST_CLASH_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      (!io_rd_n && !io_wr_n) |-> (!dq_oe_lo && !dq_oe_hi)); // R10

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (bank_flat == '0)); // R11

   AST_LO_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !dq_oe_lo |-> (dq_out[DATA_W-1:0] == '0)); // R12

   AST_HI_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !dq_oe_hi |-> (dq_out[2*DATA_W-1:DATA_W] == '0)); // R12

endmodule

bind tfile_lane_bridge tfile_lane_bridge_chk #(.DATA_W(DATA_W), .PAIR_AW(PAIR_AW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cs_lo_n   (cs_lo_n),
   .cs_hi_n   (cs_hi_n),
   .regsel_n  (regsel_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .io_rd_n   (io_rd_n),
   .io_wr_n   (io_wr_n),
   .dq_out    (dq_out),
   .dq_oe_lo  (dq_oe_lo),
   .dq_oe_hi  (dq_oe_hi),
   .bank_flat (bank_flat)
);

// File: tb/tfile_lane_bridge_bench.sv
module tfile_lane_bridge_bench;

   localparam int DW   = 8;
   localparam int PAW  = 2;
   localparam int NREG = 2 << PAW;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           cs_lo_n = 1'b1, cs_hi_n = 1'b1, regsel_n = 1'b1;
   logic           mem_oe_n = 1'b1, mem_we_n = 1'b1;
   logic           io_rd_n = 1'b1, io_wr_n = 1'b1;
   logic [PAW:0]   addr = '0;
   logic [2*DW-1:0] dq_in = '0;
   logic [2*DW-1:0] dq_out;
   logic           dq_oe_lo, dq_oe_hi;

   int             n_checks = 0;
   int             n_fail   = 0;
   bit             done     = 1'b0;
   logic [DW-1:0]  model [NREG];

   always #10 clk = ~clk;

   tfile_lane_bridge #(.DATA_W(DW), .PAIR_AW(PAW)) u_tfile_lane_bridge (
      .clk(clk), .rst(rst), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
      .regsel_n(regsel_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_idle();
      cs_lo_n = 1; cs_hi_n = 1; regsel_n = 1; mem_oe_n = 1; mem_we_n = 1;
      io_rd_n = 1; io_wr_n = 1;
   endtask

   // Expected effect of a write cycle on the model, per R1, R2, R4, R6, R8, R10
   task automatic model_write(input logic lo_n, input logic hi_n, input logic rs_n,
                              input logic oe_n, input logic we_n, input logic rd_low,
                              input logic [PAW:0] a, input logic [2*DW-1:0] d);
      int base = {a[PAW:1], 1'b0};
      if (rs_n || !oe_n || !we_n || rd_low || (lo_n && hi_n)) return;
      if (!lo_n && hi_n) model[base + a[0]] = d[DW-1:0];
      else if (!lo_n && !hi_n) begin
         model[base]     = d[DW-1:0];
         model[base + 1] = d[2*DW-1:DW];
      end else model[base + 1] = d[2*DW-1:DW];
   endtask

   // Write cycle: strobe low for one edge, high on the next (R9)
   task automatic do_write(input logic lo_n, input logic hi_n, input logic rs_n,
                           input logic oe_n, input logic we_n, input logic rd_low,
                           input logic [PAW:0] a, input logic [2*DW-1:0] d);
      @(negedge clk);
      cs_lo_n = lo_n; cs_hi_n = hi_n; regsel_n = rs_n; mem_oe_n = oe_n; mem_we_n = we_n;
      io_rd_n = !rd_low; io_wr_n = 0; addr = a; dq_in = d;
      @(negedge clk);
      io_wr_n = 1; io_rd_n = 1;
      dq_in = ~d;
      @(negedge clk);
      bus_idle();
      model_write(lo_n, hi_n, rs_n, oe_n, we_n, rd_low, a, d);
   endtask

   // Read cycle checked against values computed from R1-style rules
   task automatic do_read(input logic lo_n, input logic hi_n, input logic rs_n,
                          input logic oe_n, input logic we_n, input logic wr_low,
                          input logic [PAW:0] a, input string req);
      logic e_lo, e_hi;
      logic [2*DW-1:0] e_d;
      int base = {a[PAW:1], 1'b0};
      logic ok = !rs_n && oe_n && we_n && !wr_low && !(lo_n && hi_n);
      e_lo = ok && !lo_n;
      e_hi = ok && !hi_n;
      e_d  = '0;
      if (e_lo) e_d[DW-1:0]    = (hi_n && a[0]) ? model[base + 1] : model[base];
      if (e_hi) e_d[2*DW-1:DW] = model[base + 1];
      @(negedge clk);
      cs_lo_n = lo_n; cs_hi_n = hi_n; regsel_n = rs_n; mem_oe_n = oe_n; mem_we_n = we_n;
      io_rd_n = 0; io_wr_n = !wr_low; addr = a;
      #5;
      check({req, " oe_lo"}, {31'd0, dq_oe_lo}, {31'd0, e_lo});
      check({req, " oe_hi"}, {31'd0, dq_oe_hi}, {31'd0, e_hi});
      check({req, " data"}, {16'd0, dq_out}, {16'd0, e_d});
      @(negedge clk);
      bus_idle();
   endtask

   task automatic readback_all(input string req);
      for (int p = 0; p < (1 << PAW); p++)
         do_read(0, 0, 0, 1, 1, 0, {p[PAW-1:0], 1'b0}, req);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      for (int i = 0; i < NREG; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      check("R12 reset lanes", {16'd0, dq_out}, 32'd0);
      check("R1 reset oe", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
      readback_all("R11 after reset");

      // R6 / R5: word writes and reads, a0 both values
      do_write(0, 0, 0, 1, 1, 0, 3'b000, 16'hA155);
      do_write(0, 0, 0, 1, 1, 0, 3'b011, 16'hB266);
      do_write(0, 0, 0, 1, 1, 0, 3'b100, 16'hC377);
      do_write(0, 0, 0, 1, 1, 0, 3'b111, 16'hD488);
      readback_all("R6 word write");
      do_read(0, 0, 0, 1, 1, 0, 3'b011, "R5 word read a0=1");

      // R4 / R3: byte mode, high lane garbage must not land
      do_write(0, 1, 0, 1, 1, 0, 3'b010, 16'hEE12);
      do_write(0, 1, 0, 1, 1, 0, 3'b101, 16'hEE34);
      do_read(0, 1, 0, 1, 1, 0, 3'b010, "R3 byte even");
      do_read(0, 1, 0, 1, 1, 0, 3'b011, "R3 byte odd");
      do_read(0, 0, 0, 1, 1, 0, 3'b010, "R4 byte write pair1");
      do_read(0, 0, 0, 1, 1, 0, 3'b100, "R4 byte write pair2");

      // R8 / R7: odd mode, low lane garbage must not land
      do_write(1, 0, 0, 1, 1, 0, 3'b110, 16'h5AFF);
      do_read(1, 0, 0, 1, 1, 0, 3'b110, "R7 odd read");
      do_read(0, 0, 0, 1, 1, 0, 3'b110, "R8 odd write");

      // R1: standby writes ignored
      do_write(1, 1, 0, 1, 1, 0, 3'b000, 16'h0000);
      do_read(1, 1, 0, 1, 1, 0, 3'b000, "R1 standby read");
      // R2: disqualified cycles
      do_write(0, 0, 1, 1, 1, 0, 3'b000, 16'h1111);
      do_write(0, 0, 0, 0, 1, 0, 3'b010, 16'h2222);
      do_write(0, 0, 0, 1, 0, 0, 3'b100, 16'h3333);
      do_read(0, 0, 1, 1, 1, 0, 3'b000, "R2 regsel high read");
      do_read(0, 0, 0, 0, 1, 0, 3'b000, "R2 mem oe low read");
      readback_all("R2 no write");
      // R10: both strobes low
      do_write(0, 0, 0, 1, 1, 1, 3'b110, 16'h9999);
      do_read(0, 0, 0, 1, 1, 1, 3'b110, "R10 clash read");
      readback_all("R10 no write");

      // R9: strobe held low two edges, data changes; last sample wins
      @(negedge clk);
      cs_lo_n = 0; cs_hi_n = 0; regsel_n = 0; io_wr_n = 0; addr = 3'b010; dq_in = 16'h1234;
      @(negedge clk);
      dq_in = 16'h5678;
      @(negedge clk);
      io_wr_n = 1; dq_in = 16'hFFFF;
      @(negedge clk);
      bus_idle();
      model[2] = 8'h78; model[3] = 8'h56;
      do_read(0, 0, 0, 1, 1, 0, 3'b010, "R9 last low sample");

      // Random mix
      for (int it = 0; it < 400; it++) begin
         logic lo_n = 1'($urandom);
         logic hi_n = 1'($urandom);
         logic rs_n = ($urandom % 8) == 0;
         logic oe_n = ($urandom % 8) != 0;
         logic we_n = ($urandom % 8) != 0;
         logic clash = ($urandom % 10) == 0;
         logic [PAW:0] a = PAW'($urandom) + 1'b0;
         logic [2*DW-1:0] d = 16'($urandom);
         a = (PAW+1)'($urandom);
         if ($urandom % 2) do_write(lo_n, hi_n, rs_n, oe_n, we_n, clash, a, d);
         else do_read(lo_n, hi_n, rs_n, oe_n, we_n, clash, a, "R3 R5 R7 random read");
      end
      readback_all("R4 R6 R8 random readback");

      // R11: reset mid-run
      @(negedge clk);
      rst = 1;
      @(negedge clk);
      rst = 0;
      for (int i = 0; i < NREG; i++) model[i] = '0;
      readback_all("R11 mid-run reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule